// File: doc/BRIEF.md
# Group-Scaled FP4 Quantizer

This block turns a stream of signed fixed-point samples into 4-bit floating-point codes with one exponent pair and one mantissa bit. The stream is cut into groups of `GROUP_LEN` consecutive samples. The block stores a whole group, finds the largest absolute value in it, and then encodes every stored sample against that maximum. The encoding is equivalent to dividing the sample by (maximum / 6) and rounding to the nearest representable magnitude. It does this without a divider: it compares 6·|x| against the maximum scaled by each midpoint between neighbouring magnitudes.

Each group leaves the block as one scale beat followed by `GROUP_LEN` code beats. The scale beat carries the raw group maximum; the effective scale is that value divided by six. Both edges use valid/ready handshakes. Two group buffers alternate, so one group can be collected while the previous one is being drained.

Top module: `fp4_group_quant`

## Requirements
- R1: Every group is emitted as exactly one beat with `out_sog`=1, then `GROUP_LEN` beats with `out_sog`=0 carrying the codes of the group's samples in arrival order.
- R2: On the `out_sog` beat, `out_scale` equals the largest absolute sample value of the group as an unsigned number. The most negative sample -2^(SAMPLE_W-1) counts as magnitude 2^(SAMPLE_W-1).
- R3: A code is {sign, exp[1:0], man} in bits [3], [2:1] and [0]. Its low three bits form a magnitude index 0..7 that stands for 0, 0.5, 1, 1.5, 2, 3, 4 and 6.
- R4: The chosen index is the one whose magnitude is nearest to 6·|x|/max. A sample whose magnitude equals the group maximum gets index 7.
- R5: When 6·|x|/max lies exactly between two magnitudes, the index with mantissa bit 0 (the even index) is chosen.
- R6: The sign bit equals the sample's sign, except that a result of index 0 is always emitted as 4'b0000.
- R7: A group in which every sample is zero produces scale 0 and all codes 4'b0000.
- R8: While one group is waiting to be drained, a second full group is accepted without back-pressure. `in_ready` falls only when both group buffers hold complete groups.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sog`, `out_scale` and `out_code` hold their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | SAMPLE_W | Signed two's-complement sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_sog | output | 1 | Start of group: this beat is the scale record |
| out_scale | output | SAMPLE_W | Unsigned group maximum magnitude (meaningful on the scale beat) |
| out_code | output | 4 | FP4 code {sign, exp[1:0], man} (zero on the scale beat) |

## Verification
The hardest state to reach from the ports is two complete groups held at once, with the output stalled in the middle of its first beat. It is the only state in which `in_ready` may fall, and the only one in which a mistake in bank selection would mix up two groups. The bench holds `out_ready` low while it pushes two back-to-back groups, counts any input stall cycles, and then confirms that the input is blocked. Exact rounding ties are reached by a directed group with maximum 2400: that choice puts each midpoint magnitude (100, 300, 500, 700, 1000, 1400, 2000) exactly on a boundary.

// File: rtl/fp4q_pkg.sv
package fp4q_pkg;

   localparam int NUM_BOUNDS = 7;

   // Midpoints between neighbouring magnitudes, times four.
   function automatic int mid_x4(input int k);
      case (k)
         0: return 1;
         1: return 3;
         2: return 5;
         3: return 7;
         4: return 10;
         5: return 14;
         default: return 20;
      endcase
   endfunction

   // A tie at boundary k goes up when the lower index is odd (odd mantissa).
   function automatic bit tie_goes_up(input int k);
      return (k % 2) == 1;
   endfunction

endpackage

// File: rtl/fp4q_encoder.sv
module fp4q_encoder #(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] grp_max,
   output logic [3:0]          code
);
   localparam int PW = SAMPLE_W + 5;

   logic [SAMPLE_W-1:0] mag;
   logic [PW-1:0]       lhs;
   logic [fp4q_pkg::NUM_BOUNDS-1:0] step;
   logic [2:0]          idx;

   assign mag = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
   // 24*|x| compared with 4*midpoint*max
   assign lhs = ({5'b0, mag} << 4) + ({5'b0, mag} << 3);

   for (genvar k = 0; k < fp4q_pkg::NUM_BOUNDS; k++) begin : g_bnd
      localparam int  C  = fp4q_pkg::mid_x4(k);
      localparam bit  UP = fp4q_pkg::tie_goes_up(k);
      logic [PW-1:0] rhs;
      assign rhs = PW'(grp_max) * PW'(C);
      assign step[k] = (lhs > rhs) || (UP && (lhs == rhs));
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < fp4q_pkg::NUM_BOUNDS; k++)
         idx = idx + {2'b0, step[k]};
   end

   always_comb begin
      if (grp_max == '0 || idx == '0)
         code = 4'b0000;
      else
         code = {sample[SAMPLE_W-1], idx};
   end
endmodule

// File: rtl/fp4q_pingpong.sv
module fp4q_pingpong #(
   parameter int SAMPLE_W  = 16,
   parameter int GROUP_LEN = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_valid,
   input  logic [SAMPLE_W-1:0]          wr_data,
   output logic                         wr_ready,
   input  logic [$clog2(GROUP_LEN)-1:0] rd_idx,
   input  logic                         rd_release,
   output logic                         rd_full,
   output logic [SAMPLE_W-1:0]          rd_sample,
   output logic [SAMPLE_W-1:0]          rd_max
);
   localparam int IW    = $clog2(GROUP_LEN);
   localparam int DEPTH = 2 * GROUP_LEN;
   localparam int AW    = $clog2(DEPTH);

   logic [SAMPLE_W-1:0] mem [DEPTH];
   logic [SAMPLE_W-1:0] bank_max [2];
   logic [1:0]          bank_full;
   logic                wr_bank, rd_bank;
   logic [IW-1:0]       wr_cnt;
   logic                accept, wr_last;
   logic [SAMPLE_W-1:0] wr_mag;
   logic [AW-1:0]       wr_addr, rd_addr;

   assign wr_ready = !bank_full[wr_bank];
   assign accept   = wr_valid && wr_ready;
   assign wr_last  = (wr_cnt == IW'(GROUP_LEN - 1));
   assign wr_mag   = wr_data[SAMPLE_W-1] ? (~wr_data + 1'b1) : wr_data;
   assign wr_addr  = AW'(wr_cnt) + (wr_bank ? AW'(GROUP_LEN) : AW'(0));
   assign rd_addr  = AW'(rd_idx) + (rd_bank ? AW'(GROUP_LEN) : AW'(0));

   always_ff @(posedge clk) begin
      if (accept)
         mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bank <= 1'b0;
         wr_cnt  <= '0;
         rd_bank <= 1'b0;
      end else begin
         if (accept) begin
            wr_cnt <= wr_last ? '0 : wr_cnt + 1'b1;
            if (wr_last)
               wr_bank <= ~wr_bank;
         end
         if (rd_release)
            rd_bank <= ~rd_bank;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_full   <= '0;
         bank_max[0] <= '0;
         bank_max[1] <= '0;
      end else begin
         for (int b = 0; b < 2; b++) begin
            if (accept && (wr_bank == b[0])) begin
               if (wr_cnt == '0 || wr_mag > bank_max[b])
                  bank_max[b] <= wr_mag;
               if (wr_last)
                  bank_full[b] <= 1'b1;
            end
            if (rd_release && (rd_bank == b[0]))
               bank_full[b] <= 1'b0;
         end
      end
   end

   assign rd_full   = bank_full[rd_bank];
   assign rd_sample = mem[rd_addr];
   assign rd_max    = bank_max[rd_bank];
endmodule

// File: rtl/fp4_group_quant.sv
module fp4_group_quant #(
   parameter int SAMPLE_W  = 16,
   parameter int GROUP_LEN = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic                out_sog,
   output logic [SAMPLE_W-1:0] out_scale,
   output logic [3:0]          out_code
);
   localparam int IW = $clog2(GROUP_LEN);
   localparam int PW = $clog2(GROUP_LEN + 1);

   if (GROUP_LEN < 32 || GROUP_LEN > 128) begin : g_bad_len
      $error("GROUP_LEN must lie in 32..128");
   end
   if (SAMPLE_W < 4 || SAMPLE_W > 26) begin : g_bad_w
      $error("SAMPLE_W must lie in 4..26");
   end

   logic [PW-1:0]       rd_pos;
   logic [IW-1:0]       rd_idx;
   logic                rd_full, rd_release, out_fire;
   logic [SAMPLE_W-1:0] rd_sample, rd_max;
   logic [3:0]          enc_code;

   assign out_fire   = out_valid && out_ready;
   assign rd_release = out_fire && (rd_pos == PW'(GROUP_LEN));
   assign rd_idx     = (rd_pos == '0) ? '0 : IW'(rd_pos - 1'b1);

   fp4q_pingpong #(.SAMPLE_W(SAMPLE_W), .GROUP_LEN(GROUP_LEN)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (in_valid),
      .wr_data   (in_data),
      .wr_ready  (in_ready),
      .rd_idx    (rd_idx),
      .rd_release(rd_release),
      .rd_full   (rd_full),
      .rd_sample (rd_sample),
      .rd_max    (rd_max)
   );

   fp4q_encoder #(.SAMPLE_W(SAMPLE_W)) u_enc (
      .sample (rd_sample),
      .grp_max(rd_max),
      .code   (enc_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_pos <= '0;
      else if (out_fire)
         rd_pos <= (rd_pos == PW'(GROUP_LEN)) ? '0 : rd_pos + 1'b1;
   end

   assign out_valid = rd_full;
   assign out_sog   = (rd_pos == '0);
   assign out_scale = rd_max;
   assign out_code  = out_sog ? 4'b0000 : enc_code;
endmodule

// File: rtl/fp4q_checker.sv
module fp4q_checker #(
   parameter int SAMPLE_W  = 16,
   parameter int GROUP_LEN = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                out_valid,
   input logic                out_ready,
   input logic                out_sog,
   input logic [SAMPLE_W-1:0] out_scale,
   input logic [3:0]          out_code
);
   localparam int CW = $clog2(GROUP_LEN + 1);

   logic [CW-1:0] codes_seen;
   logic          zero_grp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         codes_seen <= CW'(GROUP_LEN);
         zero_grp   <= 1'b0;
      end else if (out_valid && out_ready) begin
         if (out_sog) begin
            codes_seen <= '0;
            zero_grp   <= (out_scale == '0);
         end else begin
            codes_seen <= codes_seen + 1'b1;
         end
      end
   end

   p_framing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sog == (codes_seen == CW'(GROUP_LEN))));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sog)
                                     && $stable(out_scale) && $stable(out_code)));

   p_no_neg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sog && out_code[2:0] == 3'b000) |-> !out_code[3]);

   p_zero_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sog && zero_grp) |-> (out_code == 4'b0000));
endmodule

bind fp4_group_quant fp4q_checker #(.SAMPLE_W(SAMPLE_W), .GROUP_LEN(GROUP_LEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_sog  (out_sog),
   .out_scale(out_scale),
   .out_code (out_code)
);

// File: tb/fp4_group_quant_bench.sv
`timescale 1ns/1ps
module fp4_group_quant_bench;
   localparam int W  = 16;
   localparam int GL = 64;

   typedef struct {
      bit          sog;
      int          scale;
      logic [3:0]  code;
      string       tag;
   } beat_t;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, in_ready, out_valid, out_ready = 0, out_sog;
   logic [W-1:0] in_data = '0, out_scale;
   logic [3:0]   out_code;

   int tests = 0, fails = 0, stalls = 0, ready_mode = 1;
   bit finished = 0;
   int grp [GL];
   beat_t expq [$];

   always #4 clk = ~clk;

   fp4_group_quant u_fp4_group_quant (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_sog(out_sog), .out_scale(out_scale), .out_code(out_code));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_code(input int x, input int mx);
      real mags [8] = '{0.0, 0.5, 1.0, 1.5, 2.0, 3.0, 4.0, 6.0};
      real q, d, bd;
      int a, best;
      if (mx == 0) return 4'b0000;
      a = (x < 0) ? -x : x;
      q = 6.0 * a / mx;
      best = 0; bd = 1.0e9;
      for (int i = 0; i < 8; i++) begin
         d = (q > mags[i]) ? q - mags[i] : mags[i] - q;
         if (d < bd || (d == bd && (i % 2) == 0 && (best % 2) == 1)) begin
            bd = d; best = i;
         end
      end
      if (best == 0) return 4'b0000;
      return {(x < 0), 3'(best)};
   endfunction

   // Driver: queue expected beats, then push samples (call right after a negedge).
   task automatic send_group(input string tag);
      int mx = 0;
      beat_t b;
      for (int i = 0; i < GL; i++) begin
         int a = (grp[i] < 0) ? -grp[i] : grp[i];
         if (a > mx) mx = a;
      end
      b.sog = 1; b.scale = mx; b.code = 0; b.tag = "R2";
      expq.push_back(b);
      for (int i = 0; i < GL; i++) begin
         b.sog = 0; b.scale = 0; b.code = ref_code(grp[i], mx); b.tag = tag;
         expq.push_back(b);
      end
      for (int i = 0; i < GL; i++) begin
         in_valid = 1;
         in_data  = W'(grp[i]);
         while (!in_ready) begin
            stalls++;
            @(negedge clk);
         end
         @(negedge clk);
      end
      in_valid = 0;
   endtask

   // Monitor / scoreboard
   initial begin
      bit   stalled = 0;
      logic [W+4:0] snap = '0;
      beat_t e;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (stalled)
               check(out_valid && {out_sog, out_scale, out_code} == snap, "R9",
                     "held beat changed", int'({out_sog, out_scale, out_code}), int'(snap));
            stalled = out_valid && !out_ready;
            snap = {out_sog, out_scale, out_code};
            if (out_valid && out_ready) begin
               if (expq.size() == 0) begin
                  check(0, "R1", "unexpected beat", int'(out_sog), -1);
               end else begin
                  e = expq.pop_front();
                  check(out_sog == e.sog, "R1", "sog flag", int'(out_sog), int'(e.sog));
                  if (e.sog)
                     check(int'(out_scale) == e.scale, e.tag, "scale", int'(out_scale), e.scale);
                  else
                     check(out_code == e.code, e.tag, "code", int'(out_code), int'(e.code));
               end
            end
         end
         @(posedge clk);
         #1;
         case (ready_mode)
            0: out_ready = 0;
            1: out_ready = 1;
            default: out_ready = 1'($urandom_range(0, 1));
         endcase
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int tie_mag [8] = '{100, 300, 500, 700, 1000, 1400, 2000, 2400};
      int exact [8]   = '{0, 500, 1000, 1500, 2000, 3000, 4000, 6000};
      repeat (3) @(negedge clk);
      // R10: reset state
      check(out_valid == 0, "R10", "out_valid in reset", int'(out_valid), 0);
      check(in_ready == 1, "R10", "in_ready in reset", int'(in_ready), 1);
      rst_n = 1;
      @(negedge clk);
      ready_mode = 1;

      // R3: exact magnitudes map to each index, both signs
      for (int i = 0; i < GL; i++) grp[i] = ((i / 8) % 2) ? -exact[i % 8] : exact[i % 8];
      send_group("R3");
      // R5: every midpoint exactly on a boundary
      for (int i = 0; i < GL; i++) grp[i] = ((i / 8) % 2) ? -tie_mag[i % 8] : tie_mag[i % 8];
      send_group("R5");
      // R7: all-zero group
      for (int i = 0; i < GL; i++) grp[i] = 0;
      send_group("R7");
      // R4: ramp across the range
      for (int i = 0; i < GL; i++) grp[i] = (i - 20) * 371;
      send_group("R4");
      // R6: small negatives that round to zero or just above
      for (int i = 0; i < GL; i++) grp[i] = -(90 + i);
      grp[5] = 2400;
      send_group("R6");

      repeat (300) @(negedge clk);
      check(expq.size() == 0, "R1", "beats left after drain", expq.size(), 0);

      // R8: two groups with output stalled, no input stall allowed
      ready_mode = 0;
      repeat (2) @(negedge clk);
      stalls = 0;
      for (int i = 0; i < GL; i++) grp[i] = (i * 977) % 20001 - 10000;
      send_group("R8");
      for (int i = 0; i < GL; i++) grp[i] = 5000 - i * 150;
      send_group("R8");
      check(stalls == 0, "R8", "input stalls over two groups", stalls, 0);
      @(negedge clk);
      check(in_ready == 0, "R8", "in_ready with both buffers full", int'(in_ready), 0);
      check(out_valid == 1, "R8", "out_valid with both buffers full", int'(out_valid), 1);
      check(out_sog == 1, "R1", "first pending beat is scale", int'(out_sog), 1);
      ready_mode = 2;

      // R2: most negative sample, plus random groups under random back-pressure
      for (int i = 0; i < GL; i++) grp[i] = int'($urandom_range(0, 600)) - 300;
      grp[17] = -32768;
      send_group("R2");
      for (int g = 0; g < 3; g++) begin
         for (int i = 0; i < GL; i++) grp[i] = int'($urandom_range(0, 65535)) - 32768;
         send_group("R4");
      end
      for (int i = 0; i < GL; i++) grp[i] = int'($urandom_range(0, 2000)) - 1000;
      send_group("R6");

      ready_mode = 1;
      repeat (400) @(negedge clk);
      check(expq.size() == 0, "R1", "beats left at end", expq.size(), 0);
      check(out_valid == 0, "R1", "out_valid after drain", int'(out_valid), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule